// File: doc/BRIEF.md
# PDM Microphone Clock Generator with Programmable Sampler Phase

This block derives every timing strobe a PDM microphone front end needs from one fast system clock. Three counters are chained. The first counter divides the system clock into the core PDM rate. The second counter divides that rate into an intermediate rate. The third counter divides the intermediate rate into the clock level that is driven to the microphone. All outputs are single-cycle enables or levels in the system clock domain. No derived clock nets are created.

An internal sampler strobe marks when the returned PDM bit should be captured. Its position is set relative to the microphone clock rising edge in whole core periods. It can sit from three periods early to four periods late, and positions that fall outside the microphone period wrap around. A PCM strobe marks each decimated output sample. It fires once per a programmable even number of microphone periods.

A two-state sequencer gates the block. In state ST_IDLE all counters are held clear and every output is low. Transition IDLE_TO_RUN is taken when `enable` is sampled high. In state ST_RUN the counters advance. Transition RUN_TO_IDLE is taken when `enable` is sampled low. Configuration inputs are meant to be changed only while the block is in ST_IDLE.

Top module: `pdm_clock_chain`

## Requirements
- R1: In ST_RUN, `core_tick` pulses once every `div1_code`+1 system clock cycles. `div1_code` values 0, 1, 2 and 3 mean divide by 1, 2, 3 and 4. In divide-by-1 mode `core_tick` is high on every cycle.
- R2: `mid_tick` pulses once every `div2_code`+1 core ticks, using the same encoding as R1. It is never high unless `core_tick` is also high.
- R3: The microphone clock period is P = `cko_field`+1 intermediate periods. `mic_clk` is high for the first floor(P/2) intermediate periods of each period and low for the rest. `mic_rise` is high for exactly the first cycle of each high phase.
- R4: A `cko_field` of 0 makes the block run exactly as if the field were 1, and it drives `cfg_err` high. Any nonzero field drives `cfg_err` low.
- R5: `sample_strobe` fires once per microphone period, in the first cycle of a core period. Its offset from `mic_rise` is (`delay_code` − 3) core periods. Codes 0 to 2 place it 3, 2 and 1 periods early, code 3 places it on the rising edge, and codes 4 to 7 place it 1 to 4 periods late.
- R6: An offset outside the microphone period wraps modulo that period, which is M = (`div2_code`+1)·P core periods. For example, with M = 2, code 0 gives an offset of 1 and code 7 gives an offset of 0.
- R7: With `rate_field` = r > 0, `pcm_strobe` fires on every 2r-th microphone rising edge, always together with `mic_rise`. The first strobe comes on the 2r-th rising edge after entering ST_RUN.
- R8: With `rate_field` = 0, `pcm_strobe` never fires.
- R9: From the second cycle after `enable` is sampled low, all outputs except `cfg_err` are low. In the first cycle after `enable` is sampled high, `mic_rise` and `mic_clk` are high.
- R10: While `rst_n` is low, every strobe output and `mic_clk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run request for the sequencer |
| div1_code | input | 2 | First divider code (divide by code+1) |
| div2_code | input | 2 | Second divider code (divide by code+1) |
| cko_field | input | 4 | Third divider field (period = field+1; 0 is illegal) |
| delay_code | input | 3 | Sampler phase code (offset = code − 3 core periods) |
| rate_field | input | 7 | Half of the decimation ratio |
| core_tick | output | 1 | Core PDM rate enable |
| mid_tick | output | 1 | Intermediate rate enable |
| mic_clk | output | 1 | Microphone clock level |
| mic_rise | output | 1 | First cycle of each microphone clock high phase |
| sample_strobe | output | 1 | Sampler capture enable |
| pcm_strobe | output | 1 | Decimated PCM sample enable |
| cfg_err | output | 1 | Third divider field is zero |

## Verification
The bench sweeps all eight phase codes on a four-period microphone cycle. It also runs the extreme codes on a two-period cycle, where both the early and the late offsets must wrap. A design that does not reduce the offset modulo the period would leave the sampler silent or misplaced. The odd-period case checks that the high time rounds down, so a design that rounds up would show a high phase that is too long. Further tests cover field 0 aliasing to field 1, the count of rising edges before the first PCM strobe (an off-by-one decimator fires one edge early or late), a rate of 0 that must stay silent, and the one-cycle latency of the sequencer in both directions.

// File: rtl/pdm_clk_pkg.sv
package pdm_clk_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;

    // The third divider field: zero is illegal and aliases to one.
    function automatic logic [3:0] cko_effective(input logic [3:0] field);
        return (field == 4'd0) ? 4'd1 : field;
    endfunction

endpackage

// File: rtl/pdm_div_stage.sv
module pdm_div_stage #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         tick_in,
    input  logic [W-1:0] limit,
    output logic [W-1:0] cnt,
    output logic         tick_out
);

    logic at_limit;

    assign at_limit = (cnt >= limit);
    assign tick_out = en && tick_in && at_limit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!en) begin
            cnt <= '0;
        end else if (tick_in) begin
            if (at_limit) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pdm_phase_gen.sv
module pdm_phase_gen #(
    parameter int DIV_W = 2,
    parameter int CKO_W = 4,
    parameter int DLY_W = 3,
    parameter int ALIGN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             core_tick,
    input  logic [DIV_W-1:0] c2,
    input  logic [CKO_W-1:0] c3,
    input  logic [DIV_W-1:0] n2_lim,
    input  logic [CKO_W-1:0] p_lim,
    input  logic [DLY_W-1:0] delay_code,
    output logic             mic_clk,
    output logic             mic_rise,
    output logic             sample_strobe
);

    localparam int POS_W = DIV_W + CKO_W + 1;
    localparam int SW    = POS_W + 2;
    localparam logic signed [SW-1:0] ALIGN_S = SW'(ALIGN);

    logic [POS_W-1:0] n2;
    logic [POS_W-1:0] pp;
    logic [POS_W-1:0] m_len;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] half_p;
    logic [POS_W-1:0] target;
    logic signed [SW-1:0] v;
    logic signed [SW-1:0] m_s;
    logic start_q;

    // First cycle of each core period; forced on while idle so the first
    // run cycle counts as a period start.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_q <= 1'b1;
        end else if (!run) begin
            start_q <= 1'b1;
        end else begin
            start_q <= core_tick;
        end
    end

    always_comb begin
        n2     = POS_W'(n2_lim) + 1'b1;
        pp     = POS_W'(p_lim) + 1'b1;
        m_len  = n2 * pp;
        pos    = POS_W'(c3) * n2 + POS_W'(c2);
        half_p = pp >> 1;
    end

    // Reduce the signed offset into [0, m_len); |offset| <= 4, m_len >= 2.
    always_comb begin
        m_s = $signed({2'b00, m_len});
        v   = $signed({{(SW-DLY_W){1'b0}}, delay_code}) - ALIGN_S;
        for (int i = 0; i < 2; i++) begin
            if (v < 0) begin
                v = v + m_s;
            end
        end
        for (int i = 0; i < 2; i++) begin
            if (v >= m_s) begin
                v = v - m_s;
            end
        end
        target = v[POS_W-1:0];
    end

    assign mic_clk       = run && (POS_W'(c3) < half_p);
    assign mic_rise      = run && start_q && (pos == '0);
    assign sample_strobe = run && start_q && (pos == target);

endmodule

// File: rtl/pdm_decim.sv
module pdm_decim #(
    parameter int RATE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              mic_rise,
    input  logic [RATE_W-1:0] rate_field,
    output logic              pcm_strobe
);

    localparam int DEC_W = RATE_W + 1;

    logic [DEC_W-1:0] cnt;
    logic [DEC_W-1:0] last;
    logic             rate_ok;
    logic             wrap;

    assign rate_ok    = (rate_field != '0);
    assign last       = {rate_field - 1'b1, 1'b1};
    assign wrap       = (cnt >= last);
    assign pcm_strobe = run && mic_rise && rate_ok && wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || !rate_ok) begin
            cnt <= '0;
        end else if (mic_rise) begin
            if (wrap) begin
                cnt <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pdm_clock_chain.sv
module pdm_clock_chain
    import pdm_clk_pkg::*;
#(
    parameter int DIV_W  = 2,
    parameter int CKO_W  = 4,
    parameter int DLY_W  = 3,
    parameter int RATE_W = 7,
    parameter int ALIGN  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic [DIV_W-1:0]  div1_code,
    input  logic [DIV_W-1:0]  div2_code,
    input  logic [CKO_W-1:0]  cko_field,
    input  logic [DLY_W-1:0]  delay_code,
    input  logic [RATE_W-1:0] rate_field,
    output logic              core_tick,
    output logic              mid_tick,
    output logic              mic_clk,
    output logic              mic_rise,
    output logic              sample_strobe,
    output logic              pcm_strobe,
    output logic              cfg_err
);

    run_state_e       state_q;
    run_state_e       state_d;
    logic             run;
    logic [DIV_W-1:0] c1;
    logic [DIV_W-1:0] c2;
    logic [CKO_W-1:0] c3;
    logic [CKO_W-1:0] p_lim;
    logic             mic_tick;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: IDLE_TO_RUN and RUN_TO_IDLE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (enable)  state_d = ST_RUN;
            ST_RUN:  if (!enable) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State outputs
    always_comb begin
        unique case (state_q)
            ST_RUN:  run = 1'b1;
            default: run = 1'b0;
        endcase
    end

    always_comb begin
        p_lim   = CKO_W'(cko_effective(4'(cko_field)));
        cfg_err = (cko_field == '0);
    end

    pdm_div_stage #(.W(DIV_W)) i_div_core (
        .clk(clk), .rst_n(rst_n), .en(run), .tick_in(1'b1),
        .limit(div1_code), .cnt(c1), .tick_out(core_tick)
    );

    pdm_div_stage #(.W(DIV_W)) i_div_mid (
        .clk(clk), .rst_n(rst_n), .en(run), .tick_in(core_tick),
        .limit(div2_code), .cnt(c2), .tick_out(mid_tick)
    );

    pdm_div_stage #(.W(CKO_W)) i_div_mic (
        .clk(clk), .rst_n(rst_n), .en(run), .tick_in(mid_tick),
        .limit(p_lim), .cnt(c3), .tick_out(mic_tick)
    );

    pdm_phase_gen #(
        .DIV_W(DIV_W), .CKO_W(CKO_W), .DLY_W(DLY_W), .ALIGN(ALIGN)
    ) i_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .core_tick(core_tick),
        .c2(c2), .c3(c3), .n2_lim(div2_code), .p_lim(p_lim),
        .delay_code(delay_code), .mic_clk(mic_clk), .mic_rise(mic_rise),
        .sample_strobe(sample_strobe)
    );

    pdm_decim #(.RATE_W(RATE_W)) i_decim (
        .clk(clk), .rst_n(rst_n), .run(run), .mic_rise(mic_rise),
        .rate_field(rate_field), .pcm_strobe(pcm_strobe)
    );

    logic unused_ok;
    assign unused_ok = ^{c1, mic_tick};

endmodule

// File: rtl/pdm_clock_chain_chk.sv
module pdm_clock_chain_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic core_tick,
    input logic mid_tick,
    input logic mic_clk,
    input logic mic_rise,
    input logic sample_strobe,
    input logic pcm_strobe
);

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && $past(!enable)) |-> !(mic_clk || core_tick || mid_tick || mic_rise || sample_strobe || pcm_strobe)); // R9

    AST_PCM_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_strobe |-> mic_rise); // R7

    AST_RISE_MARKS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mic_clk) |-> mic_rise); // R3

    AST_RISE_IS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        mic_rise |-> mic_clk); // R3

    AST_MID_ON_CORE: assert property (@(posedge clk) disable iff (!rst_n)
        mid_tick |-> core_tick); // R2

endmodule

bind pdm_clock_chain pdm_clock_chain_chk i_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .core_tick(core_tick),
    .mid_tick(mid_tick), .mic_clk(mic_clk), .mic_rise(mic_rise),
    .sample_strobe(sample_strobe), .pcm_strobe(pcm_strobe)
);

// File: tb/test_pdm_clock_chain.sv
module test_pdm_clock_chain;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [1:0] div1_code = 2'd0;
    logic [1:0] div2_code = 2'd0;
    logic [3:0] cko_field = 4'd3;
    logic [2:0] delay_code = 3'd3;
    logic [6:0] rate_field = 7'd32;
    logic core_tick, mid_tick, mic_clk, mic_rise, sample_strobe, pcm_strobe, cfg_err;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    pdm_clock_chain i_pdm_clock_chain (
        .clk(clk), .rst_n(rst_n), .enable(enable), .div1_code(div1_code),
        .div2_code(div2_code), .cko_field(cko_field), .delay_code(delay_code),
        .rate_field(rate_field), .core_tick(core_tick), .mid_tick(mid_tick),
        .mic_clk(mic_clk), .mic_rise(mic_rise), .sample_strobe(sample_strobe),
        .pcm_strobe(pcm_strobe), .cfg_err(cfg_err)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    function automatic logic sig(input int s);
        case (s)
            0: return core_tick;
            1: return mid_tick;
            2: return mic_rise;
            3: return sample_strobe;
            default: return pcm_strobe;
        endcase
    endfunction

    task automatic wait_sig(input int s);
        int n = 0;
        while (!sig(s) && n < 5000) begin
            step();
            n++;
        end
    endtask

    task automatic gap(input int s, output int n);
        wait_sig(s);
        n = 0;
        do begin
            step();
            n++;
        end while (!sig(s) && n < 5000);
    endtask

    task automatic restart();
        enable = 1'b0;
        step();
        step();
        enable = 1'b1;
    endtask

    task automatic t_reset();
        check("R10 mic_clk in reset", mic_clk, 0);
        check("R10 strobes in reset",
              int'(core_tick | mid_tick | mic_rise | sample_strobe | pcm_strobe), 0);
        check("R4 cfg_err with field 3", cfg_err, 0);
    endtask

    task automatic t_dividers(input int d1, input int d2, input int f);
        int n;
        int hi;
        div1_code = 2'(d1); div2_code = 2'(d2); cko_field = 4'(f);
        restart();
        gap(0, n); check("R1 core tick period", n, d1 + 1);
        gap(1, n); check("R2 mid tick period", n, (d1 + 1) * (d2 + 1));
        gap(2, n); check("R3 mic period", n, (d1 + 1) * (d2 + 1) * (f + 1));
        wait_sig(2);
        hi = 0;
        while (mic_clk && hi < 5000) begin
            step();
            hi++;
        end
        check("R3 mic high time", hi, (d1 + 1) * (d2 + 1) * ((f + 1) / 2));
    endtask

    task automatic t_cfg_err();
        int n;
        div1_code = 0; div2_code = 0; cko_field = 0;
        restart();
        step();
        check("R4 cfg_err with field 0", cfg_err, 1);
        gap(2, n); check("R4 field 0 period as field 1", n, 2);
        wait_sig(2); step();
        check("R4 field 0 high one period", mic_clk, 0);
        cko_field = 1;
        step();
        check("R4 cfg_err with field 1", cfg_err, 0);
    endtask

    task automatic phase_off(input int code, output int n);
        delay_code = 3'(code);
        restart();
        wait_sig(2);
        n = 0;
        while (!sample_strobe && n < 5000) begin
            step();
            n++;
        end
    endtask

    task automatic t_phase();
        int n;
        div1_code = 1; div2_code = 0; cko_field = 3;
        for (int code = 0; code < 8; code++) begin
            phase_off(code, n);
            check($sformatf("R5 sampler offset code %0d", code), n, ((code + 5) % 4) * 2);
        end
    endtask

    task automatic t_wrap();
        int n;
        div1_code = 0; div2_code = 0; cko_field = 1;
        phase_off(0, n); check("R6 wrap early code 0", n, 1);
        phase_off(7, n); check("R6 wrap late code 7", n, 0);
        phase_off(1, n); check("R6 wrap early code 1", n, 0);
    endtask

    task automatic t_pcm();
        int rises;
        int n;
        int seen;
        div1_code = 0; div2_code = 0; cko_field = 1;
        rate_field = 2;
        restart();
        rises = 0;
        for (int k = 0; k < 100; k++) begin
            step();
            if (mic_rise) rises++;
            if (pcm_strobe) break;
        end
        check("R7 rising edges to first pcm", rises, 4);
        check("R7 pcm coincides with rise", mic_rise, 1);
        gap(4, n); check("R7 pcm gap rate 2", n, 8);
        rate_field = 5;
        restart();
        gap(4, n); check("R7 pcm gap rate 5", n, 20);
        rate_field = 0;
        restart();
        seen = 0;
        for (int k = 0; k < 200; k++) begin
            step();
            if (pcm_strobe) seen++;
        end
        check("R8 no pcm at rate 0", seen, 0);
    endtask

    task automatic t_disable();
        int seen;
        div1_code = 2; div2_code = 1; cko_field = 2;
        restart();
        for (int k = 0; k < 9; k++) step();
        enable = 1'b0;
        step();
        step();
        seen = 0;
        for (int k = 0; k < 30; k++) begin
            if (mic_clk | core_tick | mid_tick | mic_rise | sample_strobe | pcm_strobe) seen++;
            step();
        end
        check("R9 outputs quiet when disabled", seen, 0);
        enable = 1'b1;
        step();
        check("R9 mic_rise first run cycle", mic_rise, 1);
        check("R9 mic_clk first run cycle", mic_clk, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        step();
        step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_dividers(1, 2, 3);
        t_dividers(3, 0, 2);
        t_dividers(0, 0, 4);
        t_cfg_err();
        t_phase();
        t_wrap();
        t_pcm();
        t_disable();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule